// File: doc/BRIEF.md
# Four-Port Static Memory with Independent Port Controls

This block is a clocked memory of 4096 words by 8 bits that serves four fully symmetric ports. Each port has its own 12-bit address, 8-bit write data, 8-bit read data and three active-low controls: select, write strobe (low means write, high means read) and output enable. No arbitration is performed and no port ever waits. Any port may read or write any word in any cycle, including a word that other ports are touching in the same cycle.

A pad tri-state is modelled by a per-port drive flag that sits beside the read data. When the flag is low, the read data bus carries zero. Writes land on the rising clock edge. Reads are registered, so results appear one cycle after the access. Each port reports a registered standby bit, and a global standby bit shows when all four ports are deselected.

The user must keep two ports from writing one word in the same cycle. If it happens anyway, a sticky collision flag and a per-port mask record it. The word then keeps the data of the lowest-numbered writing port.

Top module: `quad_port_ram`

## Requirements
- R1: A port with select low and write strobe low stores its write data at the addressed word on the rising edge, whatever its output enable is.
- R2: A port with select low, write strobe high and output enable low shows the addressed word on its read data, with its drive flag at 1, in the cycle after the access.
- R3: A port whose output enable is high has its drive flag at 0 and its read data at 0 in the following cycle, whatever its other controls are.
- R4: A port with select high is deselected. It writes nothing, its drive flag and read data are 0 in the following cycle, and its standby bit is 1 in the following cycle; otherwise the standby bit is 0.
- R5: A port that writes has its drive flag at 0 and its read data at 0 in the following cycle, even when its output enable is low.
- R6: A word written through one port is read back by every other port from the next cycle on. A read of that word on another port in the same cycle as the write returns the old data.
- R7: The global standby output is 1 in the cycle after a cycle in which all four selects are high, and 0 after any cycle in which at least one select is low.
- R8: When two or more ports write the same address in one cycle, the collision flag is 1 from the next cycle on. Each colliding port's bit (bit n for port n) is ORed into the collision mask. The stored word takes the data of the lowest-numbered writing port.
- R9: The collision flag and mask are sticky. A synchronous clear input zeroes them on the next edge, but a new collision in the same cycle as the clear sets them again.
- R10: After reset, all read data and drive flags are 0, all standby bits and the global standby are 1, and the collision flag and mask are 0.
- R11: All four ports can write, or all four can read, different addresses in the same cycle, and each access completes independently.
- R12: All four ports can read the same address in one cycle, and each gets the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| coll_clr | input | 1 | Synchronous clear of collision flag and mask |
| sel_n | input | 4 | Active-low port select, bit n for port n |
| wr_n | input | 4 | Write strobe per port: 0 write, 1 read |
| oen_n | input | 4 | Active-low output enable per port |
| addr | input | 48 | Port addresses, port n at bits [12n+11:12n] |
| wdata | input | 32 | Write data, port n at bits [8n+7:8n] |
| rdata | output | 32 | Read data, port n at bits [8n+7:8n]; 0 when not driven |
| rdrive | output | 4 | Per-port read drive flag (tri-state stand-in) |
| standby | output | 4 | Per-port registered standby bit |
| all_standby | output | 1 | 1 when all ports were deselected last cycle |
| coll_flag | output | 1 | Sticky same-address multi-writer flag |
| coll_mask | output | 4 | Sticky mask of ports involved in collisions |

## Verification
Two pairs of functions can land in the same cycle. The first is a write on one port and a read of the same word on another port. The bench provokes it by issuing both accesses on one edge, and it expects the old word that cycle and the new word on the following read. The second is a fresh collision in the cycle where the clear is asserted. The bench raises a two-writer collision together with the clear, and it expects the flag to stay set, with the mask naming exactly the colliding ports and the stored word holding the lower port's data.

// File: rtl/qp_pkg.sv
package qp_pkg;

    // Decoded per-port operation for one cycle
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_MUTE  = 2'd3
    } qp_op_e;

endpackage

// File: rtl/qp_port_decode.sv
module qp_port_decode
    import qp_pkg::*;
(
    input  logic   sel_n,
    input  logic   wr_n,
    input  logic   oen_n,
    output qp_op_e op,
    output logic   do_write,
    output logic   do_drive
);

    always_comb begin
        if (sel_n) begin
            op = OP_IDLE;
        end else if (!wr_n) begin
            op = OP_WRITE;
        end else if (!oen_n) begin
            op = OP_READ;
        end else begin
            op = OP_MUTE;
        end
    end

    assign do_write = (op == OP_WRITE);
    assign do_drive = (op == OP_READ);

endmodule

// File: rtl/qp_collision.sv
module qp_collision #(
    parameter int NPORTS = 4,
    parameter int AW     = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NPORTS-1:0]    wr,
    input  logic [NPORTS*AW-1:0] addr,
    output logic [NPORTS-1:0]    win,
    output logic                 flag,
    output logic [NPORTS-1:0]    mask
);

    typedef struct packed {
        logic              flag;
        logic [NPORTS-1:0] mask;
    } coll_st_t;

    coll_st_t st_d, st_q;
    logic [NPORTS-1:0] hit_mask;

    // Winner and collision detection: lower index beats higher on a shared address
    always_comb begin
        win      = '0;
        hit_mask = '0;
        for (int p = 0; p < NPORTS; p++) begin
            logic beaten;
            beaten = 1'b0;
            for (int q = 0; q < NPORTS; q++) begin
                if (q != p && wr[p] && wr[q] &&
                    addr[p*AW +: AW] == addr[q*AW +: AW]) begin
                    hit_mask[p] = 1'b1;
                    if (q < p) beaten = 1'b1;
                end
            end
            win[p] = wr[p] && !beaten;
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.flag = 1'b0;
            st_d.mask = '0;
        end
        if (|hit_mask) begin
            st_d.flag = 1'b1;
            st_d.mask = st_d.mask | hit_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
    assign mask = st_q.mask;

    // R9: sticky unless cleared
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !clr) |=> st_q.flag);

    // R8: a raised flag always names at least two ports
    a_r8_mask_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag |-> ($countones(st_q.mask) >= 2));

    // R8: every winner is a writer
    a_r8_win_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (win & ~wr) == '0);

endmodule

// File: rtl/qp_storage.sv
module qp_storage #(
    parameter int NPORTS = 4,
    parameter int AW     = 12,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORTS-1:0]    win,
    input  logic [NPORTS-1:0]    rd,
    input  logic [NPORTS*AW-1:0] addr,
    input  logic [NPORTS*DW-1:0] wdata,
    output logic [NPORTS*DW-1:0] rdata,
    output logic [NPORTS-1:0]    rdrive
);

    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [NPORTS*DW-1:0] data;
        logic [NPORTS-1:0]    drive;
    } rd_st_t;

    logic [DW-1:0] mem [DEPTH];
    rd_st_t st_d, st_q;

    // Reads sample the array before this edge's writes land
    always_comb begin
        st_d = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (rd[p]) begin
                st_d.drive[p]          = 1'b1;
                st_d.data[p*DW +: DW]  = mem[addr[p*AW +: AW]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORTS; p++) begin
            if (win[p]) begin
                mem[addr[p*AW +: AW]] <= wdata[p*DW +: DW];
            end
        end
    end

    assign rdata  = st_q.data;
    assign rdrive = st_q.drive;

    // R3: an undriven port carries zero data
    generate
        for (genvar g = 0; g < NPORTS; g++) begin : g_zero_chk
            a_r3_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !rd[g] |=> (rdata[g*DW +: DW] == '0));
        end
    endgenerate

endmodule

// File: rtl/quad_port_ram.sv
module quad_port_ram
    import qp_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int AW     = 12,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 coll_clr,
    input  logic [NPORTS-1:0]    sel_n,
    input  logic [NPORTS-1:0]    wr_n,
    input  logic [NPORTS-1:0]    oen_n,
    input  logic [NPORTS*AW-1:0] addr,
    input  logic [NPORTS*DW-1:0] wdata,
    output logic [NPORTS*DW-1:0] rdata,
    output logic [NPORTS-1:0]    rdrive,
    output logic [NPORTS-1:0]    standby,
    output logic                 all_standby,
    output logic                 coll_flag,
    output logic [NPORTS-1:0]    coll_mask
);

    typedef struct packed {
        logic [NPORTS-1:0] sb;
        logic              all_sb;
    } sb_st_t;

    qp_op_e            op [NPORTS];
    logic [NPORTS-1:0] wr_req;
    logic [NPORTS-1:0] rd_req;
    logic [NPORTS-1:0] win;
    sb_st_t            sb_d, sb_q;

    generate
        for (genvar g = 0; g < NPORTS; g++) begin : g_port
            qp_port_decode i_dec (
                .sel_n    (sel_n[g]),
                .wr_n     (wr_n[g]),
                .oen_n    (oen_n[g]),
                .op       (op[g]),
                .do_write (wr_req[g]),
                .do_drive (rd_req[g])
            );
        end
    endgenerate

    qp_collision #(.NPORTS(NPORTS), .AW(AW)) i_coll (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (coll_clr),
        .wr    (wr_req),
        .addr  (addr),
        .win   (win),
        .flag  (coll_flag),
        .mask  (coll_mask)
    );

    qp_storage #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .win    (win),
        .rd     (rd_req),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .rdrive (rdrive)
    );

    always_comb begin
        sb_d = sb_q;
        for (int p = 0; p < NPORTS; p++) begin
            sb_d.sb[p] = (op[p] == OP_IDLE);
        end
        sb_d.all_sb = &sel_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sb_q <= '1;
        end else begin
            sb_q <= sb_d;
        end
    end

    assign standby     = sb_q.sb;
    assign all_standby = sb_q.all_sb;

    generate
        for (genvar g = 0; g < NPORTS; g++) begin : g_port_chk
            // R5: a writing port never drives next cycle
            a_r5_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
                (!sel_n[g] && !wr_n[g]) |=> !rdrive[g]);
            // R4: a deselected port is quiet and in standby
            a_r4_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
                sel_n[g] |=> (!rdrive[g] && standby[g]));
            // R3: output enable high mutes the port
            a_r3_oe_mutes: assert property (@(posedge clk) disable iff (!rst_n)
                oen_n[g] |=> !rdrive[g]);
        end
    endgenerate

    // R7: every port deselected leads to global standby
    a_r7_global_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (&sel_n) |=> all_standby);

    // R7: global standby implies every port bit is in standby
    a_r7_global_implies_each: assert property (@(posedge clk) disable iff (!rst_n)
        all_standby |-> (&standby));

endmodule

// File: tb/test_quad_port_ram.sv
`timescale 1ns/1ps
module test_quad_port_ram;

    localparam int NP = 4;
    localparam int AW = 12;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              coll_clr = 1'b0;
    logic [NP-1:0]     sel_n = '1;
    logic [NP-1:0]     wr_n = '1;
    logic [NP-1:0]     oen_n = '1;
    logic [NP*AW-1:0]  addr = '0;
    logic [NP*DW-1:0]  wdata = '0;
    logic [NP*DW-1:0]  rdata;
    logic [NP-1:0]     rdrive;
    logic [NP-1:0]     standby;
    logic              all_standby;
    logic              coll_flag;
    logic [NP-1:0]     coll_mask;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    quad_port_ram i_quad_port_ram (
        .clk(clk), .rst_n(rst_n), .coll_clr(coll_clr),
        .sel_n(sel_n), .wr_n(wr_n), .oen_n(oen_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdrive(rdrive),
        .standby(standby), .all_standby(all_standby),
        .coll_flag(coll_flag), .coll_mask(coll_mask)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle_all();
        sel_n = '1; wr_n = '1; oen_n = '1; coll_clr = 1'b0;
    endtask

    task automatic set_port(input int p, input bit s, input bit w, input bit o,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
        sel_n[p] = s; wr_n[p] = w; oen_n[p] = o;
        addr[p*AW +: AW]  = a;
        wdata[p*DW +: DW] = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] rd_of(input int p);
        return rdata[p*DW +: DW];
    endfunction

    task automatic t_reset();
        check("R10", "rdata", rdata, 32'h0);
        check("R10", "rdrive", rdrive, 4'h0);
        check("R10", "standby", standby, 4'hF);
        check("R10", "all_standby", all_standby, 1'b1);
        check("R10", "coll_flag", coll_flag, 1'b0);
        check("R10", "coll_mask", coll_mask, 4'h0);
    endtask

    task automatic t_write_read();
        idle_all();
        set_port(0, 0, 0, 0, 12'h123, 8'hA5);   // write with oe low: R1
        step();
        check("R5", "writer drive", rdrive[0], 1'b0);
        check("R5", "writer data", rd_of(0), 8'h00);
        check("R4", "standby active", standby[0], 1'b0);
        check("R4", "standby idle", standby[2], 1'b1);
        idle_all();
        set_port(2, 0, 1, 0, 12'h123, 8'h00);
        step();
        check("R2", "read drive", rdrive[2], 1'b1);
        check("R1", "word via port2", rd_of(2), 8'hA5);
        idle_all();
    endtask

    task automatic t_oe_high();
        idle_all();
        set_port(1, 0, 1, 1, 12'h123, 8'h00);
        step();
        check("R3", "muted drive", rdrive[1], 1'b0);
        check("R3", "muted data", rd_of(1), 8'h00);
        idle_all();
    endtask

    task automatic t_deselect();
        idle_all();
        set_port(3, 1, 0, 0, 12'h123, 8'hFF);
        step();
        check("R4", "deselected standby", standby[3], 1'b1);
        check("R4", "deselected drive", rdrive[3], 1'b0);
        set_port(3, 0, 1, 0, 12'h123, 8'h00);
        step();
        check("R4", "no write when deselected", rd_of(3), 8'hA5);
        idle_all();
    endtask

    task automatic t_old_data();
        idle_all();
        set_port(1, 0, 0, 1, 12'h123, 8'h3C);
        set_port(2, 0, 1, 0, 12'h123, 8'h00);
        step();
        check("R6", "same-cycle read old", rd_of(2), 8'hA5);
        idle_all();
        set_port(2, 0, 1, 0, 12'h123, 8'h00);
        set_port(0, 0, 1, 0, 12'h123, 8'h00);
        step();
        check("R6", "next read new p2", rd_of(2), 8'h3C);
        check("R6", "next read new p0", rd_of(0), 8'h3C);
        idle_all();
    endtask

    task automatic t_standby();
        idle_all();
        step();
        check("R7", "all deselected", all_standby, 1'b1);
        set_port(2, 0, 1, 1, 12'h000, 8'h00);
        step();
        check("R7", "one selected", all_standby, 1'b0);
        idle_all();
        step();
        check("R7", "back to standby", all_standby, 1'b1);
    endtask

    task automatic t_parallel();
        idle_all();
        for (int p = 0; p < NP; p++)
            set_port(p, 0, 0, 1, 12'h200 + 12'(p * 17), 8'h10 + 8'(p * 3));
        step();
        for (int p = 0; p < NP; p++)
            set_port(p, 0, 1, 0, 12'h200 + 12'((3 - p) * 17), 8'h00);
        step();
        for (int p = 0; p < NP; p++)
            check("R11", $sformatf("parallel port%0d", p), rd_of(p), 8'h10 + 8'((3 - p) * 3));
        for (int p = 0; p < NP; p++)
            set_port(p, 0, 1, 0, 12'h123, 8'h00);
        step();
        for (int p = 0; p < NP; p++)
            check("R12", $sformatf("shared read port%0d", p), rd_of(p), 8'h3C);
        check("R12", "all drive", rdrive, 4'hF);
        idle_all();
    endtask

    task automatic t_collision();
        idle_all();
        set_port(1, 0, 0, 0, 12'h0F0, 8'h11);
        set_port(3, 0, 0, 0, 12'h0F0, 8'h33);
        set_port(0, 0, 0, 0, 12'h0F1, 8'h77);
        step();
        check("R8", "flag set", coll_flag, 1'b1);
        check("R8", "mask", coll_mask, 4'b1010);
        idle_all();
        set_port(2, 0, 1, 0, 12'h0F0, 8'h00);
        set_port(0, 0, 1, 0, 12'h0F1, 8'h00);
        step();
        check("R8", "lowest writer kept", rd_of(2), 8'h11);
        check("R8", "bystander write", rd_of(0), 8'h77);
        check("R9", "sticky flag", coll_flag, 1'b1);
        idle_all();
        coll_clr = 1'b1;
        step();
        check("R9", "cleared flag", coll_flag, 1'b0);
        check("R9", "cleared mask", coll_mask, 4'h0);
        coll_clr = 1'b1;
        set_port(0, 0, 0, 1, 12'h0AA, 8'h01);
        set_port(2, 0, 0, 1, 12'h0AA, 8'h02);
        step();
        check("R9", "set beats clear", coll_flag, 1'b1);
        check("R9", "mask after set", coll_mask, 4'b0101);
        idle_all();
        set_port(3, 0, 1, 0, 12'h0AA, 8'h00);
        step();
        check("R8", "lowest writer p0", rd_of(3), 8'h01);
        idle_all();
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle_all();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_write_read();
        t_oe_high();
        t_deselect();
        t_old_data();
        t_standby();
        t_parallel();
        t_collision();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule